// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a bank of internal configuration registers through a four-word window instead of a full address map. The window holds a command word, a data word and a status word. To write, the host first loads the data word. It then writes the command word with the write-enable bit and the target register number. To read, the host writes the command word with only the register number. It waits until the status word shows the window ready again and then reads the result from the data word.

Only one access can be in flight at a time. Register numbers fall into two classes. The first is a fast core class, which is the low part of the number space. The second is a slow management class, which starts at a parameterised base and models registers that sit behind a slow serial management link. The sequencer holds the window busy for a fixed short time on the core class and for a configurable long time on the management class. Host writes that arrive during that window are rejected and recorded in a sticky flag.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the status word reads 1: ready (bit 0) is high and the overrun flag (bit 1) is low. The command word and the data word read zero, and every implemented register holds zero.
- R2: A command-word write accepted while ready is high drops ready on the next cycle. For a register number below MGMT_BASE (768), ready stays low for exactly 2 cycles.
- R3: For a register number at or above MGMT_BASE, ready stays low for exactly MGMT_LAT cycles (default 64).
- R4: With command bit 15 set, the data word is stored into the addressed register in the cycle that ready returns high.
- R5: With command bit 15 clear, the data word holds the addressed register's value in the cycle that ready returns high.
- R6: A read of an unimplemented register number returns zero. A write to one changes no register. Numbers 0 to 31 and MGMT_BASE to MGMT_BASE+31 are implemented.
- R7: A write to the command word or the data word while ready is low is ignored: neither word changes and no new access starts. Instead, the overrun flag (status bit 1) is set.
- R8: The overrun flag stays set until the host writes the status word with bit 1 high. A status write with bit 1 low leaves it unchanged.
- R9: The window offsets are 0 for the command word, 1 for the data word, 2 for the status word, and 3 reads zero. The command word reads back with the register number in bits [9:0], write-enable in bit 15, and zero elsewhere.
- R10: Management registers (MGMT_BASE+i) and core registers (i) are separate storage. Writing one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe for this cycle |
| host_wr | input | 1 | Host access is a write when high |
| host_addr | input | 2 | Window word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Window word selected by host_addr (combinational) |

## Verification
The bench measures how long ready stays low for both address classes. An off-by-one in the latency counter would show up as 1 or 3 cycles on the core class, or 63 or 65 on the management class. It fires command and data writes into a busy management access. A design that accepted them would overwrite the pending command or corrupt the read result, and a design that forgot the sticky flag would show bit 1 low. It reads unimplemented numbers on both sides of MGMT_BASE, where a bank with loose decoding would alias them onto real registers. It also writes the same low index in both classes, to catch a bank that shares storage between them.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  localparam int IDX_W      = 10;
  localparam int WE_BIT     = 15;
  localparam int OVR_BIT    = 1;
  localparam int RDY_BIT    = 0;

  localparam logic [1:0] WIN_CMD  = 2'd0;
  localparam logic [1:0] WIN_DATA = 2'd1;
  localparam logic [1:0] WIN_STAT = 2'd2;

  typedef struct packed {
    logic             we;
    logic [IDX_W-1:0] num;
  } ind_cmd_t;

  typedef enum logic {
    CLS_CORE = 1'b0,
    CLS_MGMT = 1'b1
  } ind_cls_t;
endpackage

// File: rtl/ind_host_window.sv
module ind_host_window
  import ind_bridge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ready,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_result,
  output logic              start,
  output logic [IDX_W-1:0]  start_num,
  output ind_cmd_t          cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic              ovr_q
);
  logic              wr_cmd, wr_data, wr_stat, reject;
  ind_cmd_t          cmd_d;
  logic              cmd_en;
  logic [DATA_W-1:0] data_d;
  logic              data_en;
  logic              ovr_d;

  always_comb begin
    wr_cmd    = host_sel && host_wr && (host_addr == WIN_CMD);
    wr_data   = host_sel && host_wr && (host_addr == WIN_DATA);
    wr_stat   = host_sel && host_wr && (host_addr == WIN_STAT);
    start     = wr_cmd && ready;
    reject    = (wr_cmd || wr_data) && !ready;
    start_num = host_wdata[IDX_W-1:0];
  end

  always_comb begin
    cmd_en    = start;
    cmd_d.we  = host_wdata[WE_BIT];
    cmd_d.num = host_wdata[IDX_W-1:0];
  end

  always_comb begin
    data_en = 1'b0;
    data_d  = data_q;
    if (wr_data && ready) begin
      data_en = 1'b1;
      data_d  = host_wdata;
    end else if (done && !cmd_q.we) begin
      data_en = 1'b1;
      data_d  = rd_result;
    end
  end

  always_comb begin
    ovr_d = ovr_q;
    if (wr_stat && host_wdata[OVR_BIT]) ovr_d = 1'b0;
    if (reject)                          ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      WIN_CMD: begin
        host_rdata[IDX_W-1:0] = cmd_q.num;
        host_rdata[WE_BIT]    = cmd_q.we;
      end
      WIN_DATA: host_rdata = data_q;
      WIN_STAT: begin
        host_rdata[RDY_BIT] = ready;
        host_rdata[OVR_BIT] = ovr_q;
      end
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ind_access_seq.sv
module ind_access_seq
  import ind_bridge_pkg::*;
#(
  parameter int MGMT_BASE = 768,
  parameter int MGMT_LAT  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_num,
  output logic             ready,
  output logic             done
);
  localparam int CORE_LAT = 2;
  localparam int MAX_LAT  = (MGMT_LAT > CORE_LAT) ? MGMT_LAT : CORE_LAT;
  localparam int CNT_W    = $clog2(MAX_LAT + 1);

  ind_cls_t         cls;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             cnt_en;

  always_comb begin
    cls      = (int'(start_num) >= MGMT_BASE) ? CLS_MGMT : CLS_CORE;
    load_val = (cls == CLS_MGMT) ? CNT_W'(MGMT_LAT - 1) : CNT_W'(CORE_LAT - 1);
    ready    = !busy_q;
    done     = busy_q && (cnt_q == '0);
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ind_reg_bank.sv
module ind_reg_bank
  import ind_bridge_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CORE_REGS = 32,
  parameter int MGMT_REGS = 32,
  parameter int MGMT_BASE = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [CORE_REGS-1:0] core_hit;
  logic [MGMT_REGS-1:0] mgmt_hit;
  logic [DATA_W-1:0]    core_q [CORE_REGS];
  logic [DATA_W-1:0]    mgmt_q [MGMT_REGS];

  for (genvar i = 0; i < CORE_REGS; i++) begin : g_core
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    assign core_hit[i] = (idx == SLOT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    core_q[i] <= '0;
      else if (wr_en && core_hit[i]) core_q[i] <= wdata;
    end
  end

  for (genvar j = 0; j < MGMT_REGS; j++) begin : g_mgmt
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(MGMT_BASE + j);
    assign mgmt_hit[j] = (idx == SLOT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    mgmt_q[j] <= '0;
      else if (wr_en && mgmt_hit[j]) mgmt_q[j] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < CORE_REGS; k++)
      if (core_hit[k]) rdata = rdata | core_q[k];
    for (int k = 0; k < MGMT_REGS; k++)
      if (mgmt_hit[k]) rdata = rdata | mgmt_q[k];
  end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_bridge_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CORE_REGS = 32,
  parameter int MGMT_REGS = 32,
  parameter int MGMT_BASE = 768,
  parameter int MGMT_LAT  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  logic              ready_w, done_w, start_w, ovr_w;
  logic [IDX_W-1:0]  start_num_w;
  ind_cmd_t          cmd_w;
  logic [DATA_W-1:0] data_w, bank_rd_w;

  ind_host_window #(.DATA_W(DATA_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ready      (ready_w),
    .done       (done_w),
    .rd_result  (bank_rd_w),
    .start      (start_w),
    .start_num  (start_num_w),
    .cmd_q      (cmd_w),
    .data_q     (data_w),
    .ovr_q      (ovr_w)
  );

  ind_access_seq #(.MGMT_BASE(MGMT_BASE), .MGMT_LAT(MGMT_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .start_num (start_num_w),
    .ready     (ready_w),
    .done      (done_w)
  );

  ind_reg_bank #(
    .DATA_W(DATA_W), .CORE_REGS(CORE_REGS),
    .MGMT_REGS(MGMT_REGS), .MGMT_BASE(MGMT_BASE)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (done_w && cmd_w.we),
    .idx   (cmd_w.num),
    .wdata (data_w),
    .rdata (bank_rd_w)
  );
endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk #(
  parameter int DATA_W    = 32,
  parameter int MGMT_BASE = 768,
  parameter int MGMT_LAT  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic [1:0]        host_addr,
  input logic [9:0]        wnum,
  input logic              wclr,
  input logic              ready,
  input logic              overrun,
  input logic [10:0]       cmd_q,
  input logic [DATA_W-1:0] data_q
);
  localparam int LW = $clog2(MGMT_LAT + 2);
  logic [LW-1:0] low_cnt;
  logic          cmd_wr, any_wr_busy, stat_clr;

  assign cmd_wr      = host_sel && host_wr && (host_addr == 2'd0);
  assign any_wr_busy = host_sel && host_wr && (host_addr == 2'd0 || host_addr == 2'd1) && !ready;
  assign stat_clr    = host_sel && host_wr && (host_addr == 2'd2) && wclr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= '0;
    else if (ready) low_cnt <= '0;
    else            low_cnt <= low_cnt + 1'b1;
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && ready) |=> !ready); // R2
  AST_CORE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && ready && (int'(wnum) < MGMT_BASE)) |=> !ready ##1 !ready ##1 ready); // R2
  AST_MGMT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(low_cnt) <= MGMT_LAT); // R3
  AST_BUSY_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr_busy |=> overrun); // R7
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(cmd_q)); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(data_q) || ready)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_clr) |=> overrun); // R8
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(
  .DATA_W(DATA_W), .MGMT_BASE(MGMT_BASE), .MGMT_LAT(MGMT_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_sel  (host_sel),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .wnum      (host_wdata[9:0]),
  .wclr      (host_wdata[1]),
  .ready     (ready_w),
  .overrun   (ovr_w),
  .cmd_q     (cmd_w),
  .data_q    (data_w)
);

// File: tb/ind_reg_bridge_test.sv
module ind_reg_bridge_test;
  localparam int CLK_P     = 10;
  localparam int MGMT_BASE = 768;
  localparam int MGMT_LAT  = 64;

  logic        clk, rst_n, host_sel, host_wr;
  logic [1:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;

  int checks = 0, errors = 0;
  bit finished = 0;

  ind_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_core [32];
  logic [31:0] m_mgmt [32];
  logic [31:0] m_data;
  logic [9:0]  m_num;
  bit          m_we, m_busy, m_ovr;
  int          m_cnt;

  function automatic logic [31:0] m_bank_rd(input int n);
    if (n < 32) return m_core[n];
    if (n >= MGMT_BASE && n < MGMT_BASE + 32) return m_mgmt[n - MGMT_BASE];
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_expect(input logic [1:0] a);
    case (a)
      2'd0: return {16'h0, m_we, 5'h0, m_num};
      2'd1: return m_data;
      2'd2: return {30'h0, m_ovr, !m_busy};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_core[i] = 0; m_mgmt[i] = 0; end
      m_data = 0; m_num = 0; m_we = 0; m_busy = 0; m_ovr = 0; m_cnt = 0;
    end else begin
      bit pre_busy;
      pre_busy = m_busy;
      if (pre_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_we) begin
            if (m_num < 32) m_core[m_num] = m_data;
            else if (m_num >= MGMT_BASE && m_num < MGMT_BASE + 32) m_mgmt[m_num - MGMT_BASE] = m_data;
          end else m_data = m_bank_rd(m_num);
        end else m_cnt--;
      end
      if (host_sel && host_wr) begin
        if (host_addr == 2'd2 && host_wdata[1]) m_ovr = 0;
        if (host_addr == 2'd0) begin
          if (pre_busy) m_ovr = 1;
          else begin
            m_we = host_wdata[15]; m_num = host_wdata[9:0]; m_busy = 1;
            m_cnt = (host_wdata[9:0] >= MGMT_BASE) ? MGMT_LAT - 1 : 1;
          end
        end
        if (host_addr == 2'd1) begin
          if (pre_busy) m_ovr = 1; else m_data = host_wdata;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-cycle comparison of the selected window word against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) check("R9 window word vs model", host_rdata, m_expect(host_addr));
  end

  task automatic hwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  // called right after hwr of a command: count cycles with ready low
  task automatic low_cycles(output int n);
    n = 0;
    host_addr = 2'd2;
    #1;
    while (host_rdata[0] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
      host_addr = 2'd2;
      #1;
    end
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    do hrd(2'd2, s); while (s[0] == 1'b0);
  endtask

  task automatic do_write(input int num, input logic [31:0] v, output int lat);
    hwr(2'd1, v);
    hwr(2'd0, 32'h8000 | num);
    low_cycles(lat);
  endtask

  task automatic do_read(input int num, output logic [31:0] v, output int lat);
    hwr(2'd1, 32'hDEAD_BEEF);
    hwr(2'd0, num);
    low_cycles(lat);
    hrd(2'd1, v);
  endtask

  initial begin
    #(CLK_P * 150000);
    $display("FAIL watchdog actual=running expected=finished");
    errors++;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int lat;
    rst_n = 0; host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    hrd(2'd2, v); check("R1 status after reset", v, 32'h1);
    hrd(2'd0, v); check("R1 command after reset", v, 32'h0);
    hrd(2'd1, v); check("R1 data after reset", v, 32'h0);
    do_read(7, v, lat); check("R1 register zero after reset", v, 32'h0);

    do_write(5, 32'hA5A5_0001, lat); check("R2 core latency", lat, 2);
    hrd(2'd0, v); check("R9 command readback", v, 32'h0000_8005);
    hrd(2'd3, v); check("R9 offset 3 reads zero", v, 32'h0);
    do_read(5, v, lat); check("R5 read core reg 5", v, 32'hA5A5_0001);
    check("R2 core read latency", lat, 2);
    do_write(31, 32'h1357_9BDF, lat);
    do_read(31, v, lat); check("R4 top core reg", v, 32'h1357_9BDF);

    do_write(MGMT_BASE + 5, 32'h0BAD_F00D, lat); check("R3 mgmt write latency", lat, MGMT_LAT);
    do_read(MGMT_BASE + 5, v, lat); check("R4 mgmt reg stored", v, 32'h0BAD_F00D);
    check("R3 mgmt read latency", lat, MGMT_LAT);
    do_read(5, v, lat); check("R10 core reg 5 independent", v, 32'hA5A5_0001);

    do_write(100, 32'hFFFF_FFFF, lat);
    do_read(100, v, lat); check("R6 unimplemented core-side reads zero", v, 32'h0);
    do_read(32, v, lat); check("R6 number 32 not aliased to 0", v, 32'h0);
    do_write(900, 32'h1234_5678, lat); check("R3 high number uses slow latency", lat, MGMT_LAT);
    do_read(900, v, lat); check("R6 unimplemented mgmt-side reads zero", v, 32'h0);
    do_read(MGMT_BASE + 32, v, lat); check("R6 just past mgmt bank", v, 32'h0);
    do_read(MGMT_BASE - 1, v, lat); check("R2 just below base is fast", lat, 2);

    // busy rejection
    hwr(2'd0, MGMT_BASE + 5);
    hwr(2'd1, 32'h5555_AAAA);
    hwr(2'd0, 32'h8000 | 5);
    hrd(2'd2, v); check("R7 overrun set while busy", v, 32'h2);
    hrd(2'd0, v); check("R7 command not replaced", v, MGMT_BASE + 5);
    wait_ready();
    hrd(2'd1, v); check("R7 read result not corrupted", v, 32'h0BAD_F00D);
    do_read(5, v, lat); check("R7 rejected write had no effect", v, 32'hA5A5_0001);
    hrd(2'd2, v); check("R8 overrun still set", v[1], 1'b1);
    hwr(2'd2, 32'h1);
    hrd(2'd2, v); check("R8 write bit1 low keeps flag", v, 32'h3);
    hwr(2'd2, 32'h2);
    hrd(2'd2, v); check("R8 flag cleared", v, 32'h1);

    // command written on the completion edge is rejected
    hwr(2'd0, 6);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = 2'd0; host_wdata = 32'h8006;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
    hrd(2'd2, v); check("R7 write on completion edge rejected", v, 32'h3);
    hwr(2'd2, 32'h2);

    do_write(MGMT_BASE, 32'hCAFE_0000, lat);
    do_read(0, v, lat); check("R10 core reg 0 unaffected", v, 32'h0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule